// File: doc/BRIEF.md
# GPIO Pad Local Control Block

This block sits beside one I/O pad. It keeps a 13-bit static configuration word for that pad and drives every bit of that word out as a static pad control line. The word is a local copy of a value held elsewhere in a memory-mapped register. The block copies the value from a configuration bus only on a clock edge where the transfer strobe is high. Between transfers the held word does not change.

The block also steers the pad's three dynamic signals: the value read from the pad, the value driven onto it and its output enable. One configuration bit decides who owns the pad. When that bit is set, the management processor owns it. When the bit is clear, the user logic owns it. The side that does not own the pad always sees a zero input.

A parameter picks the management port style:
- **Full port.** The management side has separate in, out and output-enable signals. This suits pads that serve as JTAG or as the SDO line of the housekeeping SPI.
- **Reduced port.** The management side has one wire. That wire acts as an input when output disable is set, and as an output when it is clear.

Two further rules apply in both styles:
- In the pull-up and pull-down input modes, the driven value is forced locally to the inverse of digital-mode bit 0.
- The input-disable bit blocks the pad value from reaching its owner.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: While rst_n is low, the held word takes its reset value. The reset value is 13'h1801 when JTAG_DEFAULT=1 (mode 110, output disable 0, management 1). Otherwise it is 13'h0403 (mode 001, output disable 1, management 1).
- R2: On a rising clock edge with cfg_load high, the held word takes cfg_data. On an edge with cfg_load low, the held word keeps its value. The change is visible after that edge.
- R3: The static outputs show the held word at these fields:
  - pad_dm = bits 12:10
  - pad_vtrip = bit 9
  - pad_slow = bit 8
  - pad_ana_pol = bit 7
  - pad_ana_sel = bit 6
  - pad_ana_en = bit 5
  - pad_ib_mode = bit 4
  - pad_in_dis = bit 3
  - pad_hold = bit 2
  - pad_out_dis = bit 1
  - pad_mgmt_sel = bit 0
- R4: With bit 0 = 1 and FULL_MGMT=1, pad_out follows mgmt_out and pad_oe follows mgmt_oe, whatever the output-disable bit holds. mgmt_in follows pad_in.
- R5: With bit 0 = 0, pad_out follows user_out and pad_oe equals user_oe AND NOT bit 1. user_in follows pad_in.
- R6: The side that does not own the pad sees zero. user_in is 0 while bit 0 = 1, and mgmt_in is 0 while bit 0 = 0.
- R7: While bit 3 (input disable) is 1, the owner's input reads 0.
- R8: When bits 12:10 are 010 (pull-up) or 011 (pull-down), pad_out equals NOT bit 10. This gives 1 for pull-up and 0 for pull-down, whoever owns the pad.
- R9: With FULL_MGMT=0 and bit 0 = 1, mgmt_oe has no effect. The single wire then behaves by output disable:
  - Bit 1 = 1: pad_oe = 0 and mgmt_in follows pad_in.
  - Bit 1 = 0: pad_oe = 1, pad_out follows mgmt_out and mgmt_in = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Transfer strobe |
| cfg_data | input | 13 | Configuration bus |
| pad_in | input | 1 | Value read from the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_dm | output | 3 | Digital mode |
| pad_vtrip | output | 1 | Trip point select |
| pad_slow | output | 1 | Slow slew select |
| pad_ana_pol | output | 1 | Analog bus polarity |
| pad_ana_sel | output | 1 | Analog bus select |
| pad_ana_en | output | 1 | Analog bus enable |
| pad_ib_mode | output | 1 | Input buffer mode select |
| pad_in_dis | output | 1 | Input disable |
| pad_hold | output | 1 | Holdover value |
| pad_out_dis | output | 1 | Output disable |
| pad_mgmt_sel | output | 1 | Management owns pad |
| user_out | input | 1 | User output value |
| user_oe | input | 1 | User output enable request |
| user_in | output | 1 | Pad input to user |
| mgmt_out | input | 1 | Management output value (the single wire's outbound side in reduced mode) |
| mgmt_oe | input | 1 | Management output enable (full mode only) |
| mgmt_in | output | 1 | Pad input to management |

## Verification
The held word and the static outputs change only one rising edge after a cycle with cfg_load high. The bench therefore updates its model word at that edge and compares the static outputs in the next low clock phase. All dynamic routing is combinational from the held word and the side inputs. Inputs are driven just after the falling edge and the routed outputs are sampled a few nanoseconds later, before the next rising edge, against a bench function of the model word. Two instances cover both port styles and both reset values.

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter bit FULL_MGMT    = 1'b1,
  parameter bit JTAG_DEFAULT = 1'b0,
  parameter int CFG_W        = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic [2:0]       pad_dm,
  output logic             pad_vtrip,
  output logic             pad_slow,
  output logic             pad_ana_pol,
  output logic             pad_ana_sel,
  output logic             pad_ana_en,
  output logic             pad_ib_mode,
  output logic             pad_in_dis,
  output logic             pad_hold,
  output logic             pad_out_dis,
  output logic             pad_mgmt_sel,
  input  logic             user_out,
  input  logic             user_oe,
  output logic             user_in,
  input  logic             mgmt_out,
  input  logic             mgmt_oe,
  output logic             mgmt_in
);

  localparam logic [CFG_W-1:0] RST_PLAIN = CFG_W'({3'b001, 8'h00, 2'b11});
  localparam logic [CFG_W-1:0] RST_JTAG  = CFG_W'({3'b110, 8'h00, 2'b01});
  localparam logic [CFG_W-1:0] RST_VAL   = JTAG_DEFAULT ? RST_JTAG : RST_PLAIN;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= RST_VAL;
    else if (cfg_load) cfg_q <= cfg_data;
  end

  assign pad_dm       = cfg_q[12:10];
  assign pad_vtrip    = cfg_q[9];
  assign pad_slow     = cfg_q[8];
  assign pad_ana_pol  = cfg_q[7];
  assign pad_ana_sel  = cfg_q[6];
  assign pad_ana_en   = cfg_q[5];
  assign pad_ib_mode  = cfg_q[4];
  assign pad_in_dis   = cfg_q[3];
  assign pad_hold     = cfg_q[2];
  assign pad_out_dis  = cfg_q[1];
  assign pad_mgmt_sel = cfg_q[0];

  logic pull_mode, drv_val, in_gated, mgmt_oe_eff, mgmt_rx_ok;

  assign pull_mode = (pad_dm[2:1] == 2'b01);
  assign drv_val   = pad_mgmt_sel ? mgmt_out : user_out;
  assign pad_out   = pull_mode ? ~pad_dm[0] : drv_val;
  assign in_gated  = pad_in & ~pad_in_dis;

  generate
    if (FULL_MGMT) begin : g_full
      assign mgmt_oe_eff = mgmt_oe;
      assign mgmt_rx_ok  = 1'b1;
    end else begin : g_reduced
      assign mgmt_oe_eff = ~pad_out_dis;
      assign mgmt_rx_ok  = pad_out_dis;
    end
  endgenerate

  assign pad_oe  = pad_mgmt_sel ? mgmt_oe_eff : (user_oe & ~pad_out_dis);
  assign user_in = ~pad_mgmt_sel & in_gated;
  assign mgmt_in = pad_mgmt_sel & mgmt_rx_ok & in_gated;

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable({pad_dm, pad_vtrip, pad_slow, pad_ana_pol, pad_ana_sel, pad_ana_en,
                           pad_ib_mode, pad_in_dis, pad_hold, pad_out_dis, pad_mgmt_sel})); // R2
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> {pad_dm, pad_vtrip, pad_slow, pad_ana_pol, pad_ana_sel, pad_ana_en,
                  pad_ib_mode, pad_in_dis, pad_hold, pad_out_dis, pad_mgmt_sel} == $past(cfg_data)); // R2
  AST_NONOWNER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(user_in && mgmt_in)); // R6
  AST_USER_OD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pad_mgmt_sel && pad_out_dis) |-> !pad_oe); // R5
  AST_PULL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_dm == 3'b010) |-> pad_out); // R8
  AST_INDIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pad_in_dis |-> (!user_in && !mgmt_in)); // R7

endmodule

// File: tb/tb_gpio_pad_ctrl.sv
module tb_gpio_pad_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_load, pad_in, user_out, user_oe, mgmt_out, mgmt_oe;
  logic [12:0] cfg_data;
  logic a_out, a_oe, a_uin, a_min, b_out, b_oe, b_uin, b_min;
  logic [2:0] a_dm, b_dm;
  logic a_vt, a_sl, a_ap, a_as, a_ae, a_ib, a_id, a_ho, a_od, a_ms;
  logic b_vt, b_sl, b_ap, b_as, b_ae, b_ib, b_id, b_ho, b_od, b_ms;

  int checks = 0;
  int errors = 0;
  logic [12:0] ma, mb;

  gpio_pad_ctrl #(.FULL_MGMT(1'b1), .JTAG_DEFAULT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data), .pad_in(pad_in),
    .pad_out(a_out), .pad_oe(a_oe), .pad_dm(a_dm), .pad_vtrip(a_vt), .pad_slow(a_sl),
    .pad_ana_pol(a_ap), .pad_ana_sel(a_as), .pad_ana_en(a_ae), .pad_ib_mode(a_ib),
    .pad_in_dis(a_id), .pad_hold(a_ho), .pad_out_dis(a_od), .pad_mgmt_sel(a_ms),
    .user_out(user_out), .user_oe(user_oe), .user_in(a_uin),
    .mgmt_out(mgmt_out), .mgmt_oe(mgmt_oe), .mgmt_in(a_min));

  gpio_pad_ctrl #(.FULL_MGMT(1'b0), .JTAG_DEFAULT(1'b0)) dut_r (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_data(cfg_data), .pad_in(pad_in),
    .pad_out(b_out), .pad_oe(b_oe), .pad_dm(b_dm), .pad_vtrip(b_vt), .pad_slow(b_sl),
    .pad_ana_pol(b_ap), .pad_ana_sel(b_as), .pad_ana_en(b_ae), .pad_ib_mode(b_ib),
    .pad_in_dis(b_id), .pad_hold(b_ho), .pad_out_dis(b_od), .pad_mgmt_sel(b_ms),
    .user_out(user_out), .user_oe(user_oe), .user_in(b_uin),
    .mgmt_out(mgmt_out), .mgmt_oe(mgmt_oe), .mgmt_in(b_min));

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] model(input logic [12:0] c, input bit full);
    logic mg, od, inb, o, oe, ui, mi;
    mg  = c[0];
    od  = c[1];
    inb = c[3] ? 1'b0 : pad_in;
    o   = (c[12:11] == 2'b01) ? ~c[10] : (mg ? mgmt_out : user_out);
    oe  = mg ? (full ? mgmt_oe : ~od) : (user_oe & ~od);
    ui  = mg ? 1'b0 : inb;
    mi  = !mg ? 1'b0 : (full ? inb : (od ? inb : 1'b0));
    return {o, oe, ui, mi};
  endfunction

  function automatic string tag(input logic [12:0] c, input bit full);
    if (c[12:11] == 2'b01) return "R8";
    if (c[3]) return "R7";
    if (!c[0]) return "R5/R6";
    return full ? "R4/R6" : "R9";
  endfunction

  task automatic check_all();
    chk("R3 static A", {a_dm, a_vt, a_sl, a_ap, a_as, a_ae, a_ib, a_id, a_ho, a_od, a_ms}, ma);
    chk("R3 static B", {b_dm, b_vt, b_sl, b_ap, b_as, b_ae, b_ib, b_id, b_ho, b_od, b_ms}, mb);
    chk({tag(ma, 1'b1), " full"}, {9'd0, a_out, a_oe, a_uin, a_min}, {9'd0, model(ma, 1'b1)});
    chk({tag(mb, 1'b0), " reduced"}, {9'd0, b_out, b_oe, b_uin, b_min}, {9'd0, model(mb, 1'b0)});
  endtask

  task automatic step(input logic ld, input logic [12:0] d, input logic [4:0] dyn);
    @(negedge clk);
    cfg_load = ld; cfg_data = d;
    {pad_in, user_out, user_oe, mgmt_out, mgmt_oe} = dyn;
    #3 check_all();
    @(posedge clk);
    if (ld) begin ma = d; mb = d; end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [12:0] d;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_load = 1'b1; cfg_data = 13'h1fff;
    {pad_in, user_out, user_oe, mgmt_out, mgmt_oe} = 5'b0;
    ma = 13'h1801; mb = 13'h0403;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset full/jtag", {a_dm, a_vt, a_sl, a_ap, a_as, a_ae, a_ib, a_id, a_ho, a_od, a_ms}, 13'h1801);
    chk("R1 reset reduced/plain", {b_dm, b_vt, b_sl, b_ap, b_as, b_ae, b_ib, b_id, b_ho, b_od, b_ms}, 13'h0403);
    cfg_load = 1'b0;
    rst_n = 1'b1;

    step(1'b0, 13'h1555, 5'b11111);
    chk("R2 hold without load", {a_dm, a_vt, a_sl, a_ap, a_as, a_ae, a_ib, a_id, a_ho, a_od, a_ms}, 13'h1801);
    // R4: full port ignores output disable
    step(1'b1, 13'h1803, 5'b10101);
    step(1'b0, 13'h0000, 5'b10101);
    step(1'b0, 13'h0000, 5'b10110);
    // R8: pull-up and pull-down
    step(1'b1, 13'h0803, 5'b00000);
    step(1'b0, 13'h0000, 5'b01010);
    step(1'b1, 13'h0c02, 5'b01010);
    step(1'b0, 13'h0000, 5'b11111);
    // R7: input disable
    step(1'b1, 13'h040b, 5'b11111);
    step(1'b0, 13'h0000, 5'b10000);
    // R9: reduced wire as output, mgmt_oe low
    step(1'b1, 13'h1801, 5'b10010);
    step(1'b0, 13'h0000, 5'b10000);
    // R5/R6: user owner with od clear and set
    step(1'b1, 13'h1800, 5'b11100);
    step(1'b1, 13'h0402, 5'b11100);
    step(1'b0, 13'h0000, 5'b10100);

    for (int i = 0; i < 4000; i++) begin
      d = 13'($urandom);
      if ($urandom % 4 == 0) d[12:10] = 3'b010 | 3'($urandom % 2);
      step(($urandom % 3) == 0, d, 5'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule